// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI and LO Result Registers

This block computes one integer multiply or divide at a time over many clock cycles and places the outcome in two result registers, HI and LO. A one-cycle start strobe launches an operation. The strobe comes with a two-bit operation code and two operands, and the block captures all of them on that cycle. The operation itself names no destination. Software-visible results come only from the two read ports, `hi_value` (move-from-HI) and `lo_value` (move-from-LO).

A multiply puts the upper half of the double-width product in HI and the lower half in LO. A divide puts the quotient in LO and the remainder in HI, so reading HI after a divide gives the first operand modulo the second. Signed operations first turn both operands into magnitudes. The unsigned engine then runs: shift-add for multiply, restoring subtraction for divide. Finally the result signs are corrected. The `busy` flag covers the whole run, and a start strobe that arrives while busy is dropped.

The controller has four states. ST_IDLE waits for start. ST_SETUP loads the engine. ST_ITER performs one step per cycle. ST_FINISH writes HI and LO. The transitions are:
- ST_IDLE to ST_SETUP on an accepted start.
- ST_SETUP to ST_ITER unconditionally.
- ST_ITER to ST_FINISH after the last of WIDTH steps.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` is 0 and HI and LO read 0.
- R2: A start accepted in ST_IDLE raises `busy` from the next cycle for exactly WIDTH+2 cycles (34 by default). HI and LO take their new values on the same edge at which `busy` falls.
- R3: A start strobe while `busy` is high neither restarts nor alters the running operation.
- R4: Opcode 2'b01 (unsigned multiply) leaves product bits [2W-1:W] in HI and bits [W-1:0] in LO.
- R5: Opcode 2'b00 (signed multiply) yields the two's-complement double-width product, split across HI and LO as in R4.
- R6: Opcode 2'b11 (unsigned divide) leaves the quotient in LO and the remainder in HI.
- R7: Opcode 2'b10 (signed divide) truncates the quotient toward zero, and the remainder takes the dividend's sign. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R8: HI and LO change only at the completion edge of an operation. They hold while idle and while busy.
- R9: A divide by zero runs with the normal R2 timing and raises no error. HI and LO are left undefined.
- R10: Operands and opcode are sampled only on the accepted start cycle. Later changes to them do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch strobe |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opnd_a | input | WIDTH | First operand (multiplicand or dividend) |
| opnd_b | input | WIDTH | Second operand (multiplier or divisor) |
| busy | output | 1 | High while an operation is in progress |
| hi_value | output | WIDTH | Move-from-HI read value |
| lo_value | output | WIDTH | Move-from-LO read value |

## Verification
The checker's unsigned divide property excludes a zero divisor, because R9 leaves that result undefined. The bench likewise compares no HI/LO contents after a divide by zero and checks only its timing. The result properties assume that the start that launched an operation is the one whose operands the checker captured. The stimulus meets this by scrambling operands, and by pulsing start, only while `busy` is high, which is when the block must ignore them.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FINISH
    } md_state_e;
endpackage

// File: rtl/md_sign_prep.sv
`timescale 1ns/1ps
module md_sign_prep #(
    parameter int WIDTH = 32
) (
    input  logic             is_signed,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] mag,
    output logic             neg
);
    assign neg = is_signed & value[WIDTH-1];
    assign mag = neg ? (~value + WIDTH'(1)) : value;
endmodule

// File: rtl/md_iter_core.sv
`timescale 1ns/1ps
module md_iter_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             is_div,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    output logic [WIDTH-1:0] out_hi,
    output logic [WIDTH-1:0] out_lo
);
    logic [WIDTH-1:0] acc_hi, acc_lo, oper_b;
    logic [WIDTH-1:0] nxt_hi, nxt_lo;
    logic [WIDTH:0]   mul_sum;
    logic [WIDTH:0]   div_shift;
    logic [WIDTH+1:0] div_trial;
    logic             div_ok;

    always_comb begin
        mul_sum   = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, oper_b} : '0);
        div_shift = {acc_hi, acc_lo[WIDTH-1]};
        div_trial = {1'b0, div_shift} - {2'b00, oper_b};
        div_ok    = ~div_trial[WIDTH+1];
        if (is_div) begin
            nxt_hi = div_ok ? div_trial[WIDTH-1:0] : div_shift[WIDTH-1:0];
            nxt_lo = {acc_lo[WIDTH-2:0], div_ok};
        end else begin
            nxt_hi = mul_sum[WIDTH:1];
            nxt_lo = {mul_sum[0], acc_lo[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
            oper_b <= '0;
        end else if (load) begin
            acc_hi <= '0;
            acc_lo <= mag_a;
            oper_b <= mag_b;
        end else if (step) begin
            acc_hi <= nxt_hi;
            acc_lo <= nxt_lo;
        end
    end

    assign out_hi = acc_hi;
    assign out_lo = acc_lo;
endmodule

// File: rtl/md_sign_fix.sv
`timescale 1ns/1ps
module md_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic             is_div,
    input  logic             neg_a,
    input  logic             neg_b,
    input  logic [WIDTH-1:0] raw_hi,
    input  logic [WIDTH-1:0] raw_lo,
    output logic [WIDTH-1:0] fix_hi,
    output logic [WIDTH-1:0] fix_lo
);
    localparam int DW = 2 * WIDTH;
    logic [DW-1:0] prod, prod_neg;

    always_comb begin
        prod     = {raw_hi, raw_lo};
        prod_neg = ~prod + DW'(1);
        if (is_div) begin
            fix_lo = (neg_a ^ neg_b) ? (~raw_lo + WIDTH'(1)) : raw_lo;
            fix_hi = neg_a ? (~raw_hi + WIDTH'(1)) : raw_hi;
        end else begin
            {fix_hi, fix_lo} = (neg_a ^ neg_b) ? prod_neg : prod;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             busy,
    output logic [WIDTH-1:0] hi_value,
    output logic [WIDTH-1:0] lo_value
);
    localparam int                CNT_W     = $clog2(WIDTH);
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(WIDTH - 1);

    md_state_e        state_q, state_d;
    md_op_e           op_q;
    logic             neg_a_q, neg_b_q;
    logic [WIDTH-1:0] mag_a_q, mag_b_q;
    logic [WIDTH-1:0] hi_q, lo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    logic [WIDTH-1:0] in_raw [2];
    logic [WIDTH-1:0] in_mag [2];
    logic [1:0]       in_neg;
    logic [WIDTH-1:0] core_hi, core_lo, fix_hi, fix_lo;

    assign in_raw[0] = opnd_a;
    assign in_raw[1] = opnd_b;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_prep
            md_sign_prep #(.WIDTH(WIDTH)) u_prep (
                .is_signed (~op[0]),
                .value     (in_raw[g]),
                .mag       (in_mag[g]),
                .neg       (in_neg[g])
            );
        end
    endgenerate

    assign accept = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ITER;
            ST_ITER:   if (cnt_q == LAST_STEP) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_MUL_S;
            neg_a_q <= 1'b0;
            neg_b_q <= 1'b0;
            mag_a_q <= '0;
            mag_b_q <= '0;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= md_op_e'(op);
                    neg_a_q <= in_neg[0];
                    neg_b_q <= in_neg[1];
                    mag_a_q <= in_mag[0];
                    mag_b_q <= in_mag[1];
                end
                ST_SETUP:  cnt_q <= '0;
                ST_ITER:   cnt_q <= cnt_q + CNT_W'(1);
                ST_FINISH: begin
                    hi_q <= fix_hi;
                    lo_q <= fix_lo;
                end
                default: ;
            endcase
        end
    end

    md_iter_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_SETUP),
        .step   (state_q == ST_ITER),
        .is_div (op_q[1]),
        .mag_a  (mag_a_q),
        .mag_b  (mag_b_q),
        .out_hi (core_hi),
        .out_lo (core_lo)
    );

    md_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .is_div (op_q[1]),
        .neg_a  (neg_a_q),
        .neg_b  (neg_b_q),
        .raw_hi (core_hi),
        .raw_lo (core_lo),
        .fix_hi (fix_hi),
        .fix_lo (fix_lo)
    );

    assign busy     = (state_q != ST_IDLE);
    assign hi_value = hi_q;
    assign lo_value = lo_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             busy,
    input logic [WIDTH-1:0] hi_value,
    input logic [WIDTH-1:0] lo_value
);
    localparam int DW = 2 * WIDTH;
    localparam int RW = $clog2(WIDTH + 3) + 1;

    logic [RW-1:0]    run_len;
    logic [WIDTH-1:0] a_q, b_q;
    logic [1:0]       op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            a_q     <= '0;
            b_q     <= '0;
            op_q    <= '0;
        end else begin
            run_len <= busy ? run_len + RW'(1) : '0;
            if (!busy && start) begin
                a_q  <= opnd_a;
                b_q  <= opnd_b;
                op_q <= op;
            end
        end
    end

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    assert_stay_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
    assert_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len < RW'(WIDTH + 1)) |=> busy);
    assert_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len == RW'(WIDTH + 1)) |=> !busy);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(hi_value) && $stable(lo_value)));
    assert_umul_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == 2'b01) |-> ({hi_value, lo_value} == DW'(a_q) * DW'(b_q)));
    assert_udiv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == 2'b11 && b_q != '0)
            |-> (lo_value == a_q / b_q && hi_value == a_q % b_q));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .busy     (busy),
    .hi_value (hi_value),
    .lo_value (lo_value)
);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] a = '0, b = '0;
    wire          busy;
    wire  [W-1:0] hi, lo;

    always #2.5 clk = ~clk;

    muldiv_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(a), .opnd_b(b), .busy(busy), .hi_value(hi), .lo_value(lo)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit chk_on = 0;

    // behavioural reference model
    int           m_cnt = 0;
    logic [W-1:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    bit           m_valid = 1, p_valid = 1;
    string        m_tag = "R1", p_tag = "R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic predict(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        longint          sx, sy, sp, q, r;
        longint unsigned ux, uy, up;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        ux = longint'(x);
        uy = longint'(y);
        p_valid = 1;
        case (o)
            2'b00: begin sp = sx * sy; p_hi = sp[63:32]; p_lo = sp[31:0]; p_tag = "R5"; end
            2'b01: begin up = ux * uy; p_hi = up[63:32]; p_lo = up[31:0]; p_tag = "R4"; end
            2'b10: begin
                p_tag = "R7";
                if (y == '0) begin p_valid = 0; p_tag = "R9"; end
                else begin q = sx / sy; r = sx % sy; p_lo = q[31:0]; p_hi = r[31:0]; end
            end
            default: begin
                p_tag = "R6";
                if (y == '0) begin p_valid = 0; p_tag = "R9"; end
                else begin p_lo = W'(ux / uy); p_hi = W'(ux % uy); end
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_hi = '0; m_lo = '0; m_valid = 1; m_tag = "R1";
            chk_on = 1;
        end else if (m_cnt == 0) begin
            if (start) begin
                m_cnt = W + 2;
                predict(op, a, b);
            end
        end else begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_valid = p_valid; m_tag = p_tag;
                if (p_valid) begin m_hi = p_hi; m_lo = p_lo; end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            check(busy == (m_cnt != 0), "R2", "busy", W'(busy), W'(m_cnt != 0));
            if (m_valid && m_cnt == 0) begin
                check(hi == m_hi, m_tag, "hi", hi, m_hi);
                check(lo == m_lo, m_tag, "lo", lo, m_lo);
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    // mode 0: plain; 1: scramble inputs while busy (R10); 2: extra start while busy (R3)
    task automatic run_op(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                          input int mode, input string tag);
        int n;
        @(posedge clk); #1;
        start = 1'b1; op = o; a = x; b = y;
        @(posedge clk); #1;
        start = 1'b0;
        if (mode == 1) begin a = $urandom; b = $urandom; op = 2'($urandom); end
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
            if (mode == 2 && n == 10) begin
                start = 1'b1; a = $urandom; b = $urandom; op = 2'($urandom);
            end
            if (mode == 2 && n == 11) start = 1'b0;
        end
        if (m_tag == "R9") check(n == W + 2, "R9", "div0 busy length", W'(n), W'(W + 2));
        else begin
            check(n == W + 2, tag, "busy length", W'(n), W'(W + 2));
            check(hi == m_hi, tag, "hi after op", hi, m_hi);
            check(lo == m_lo, tag, "lo after op", lo, m_lo);
        end
    endtask

    initial begin
        logic [W-1:0] keep_hi, keep_lo;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", W'(busy), '0);
        check(hi == '0, "R1", "hi in reset", hi, '0);
        check(lo == '0, "R1", "lo in reset", lo, '0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && hi == '0 && lo == '0, "R1", "after reset", hi | lo, '0);

        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4");
        check(hi == 32'hFFFF_FFFE && lo == 32'h0000_0001, "R4", "max*max", hi, 32'hFFFF_FFFE);
        run_op(2'b01, 32'h0001_0000, 32'h0001_0000, 0, "R4");
        run_op(2'b00, 32'hFFFF_FFFF, 32'd5, 0, "R5");
        check(hi == 32'hFFFF_FFFF && lo == 32'hFFFF_FFFB, "R5", "-1*5", lo, 32'hFFFF_FFFB);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R5");
        run_op(2'b00, 32'hFFFF_FFF9, 32'd3, 0, "R5");
        run_op(2'b11, 32'hFFFF_FFFF, 32'd10, 0, "R6");
        run_op(2'b11, 32'd3, 32'd7, 0, "R6");
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0, "R7");
        check(lo == 32'hFFFF_FFFD && hi == 32'hFFFF_FFFF, "R7", "-7/2", lo, 32'hFFFF_FFFD);
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0, "R7");
        check(lo == 32'hFFFF_FFFD && hi == 32'd1, "R7", "7/-2", hi, 32'd1);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
        check(lo == 32'h8000_0000 && hi == '0, "R7", "min/-1", lo, 32'h8000_0000);

        keep_hi = hi; keep_lo = lo;
        repeat (6) @(negedge clk);
        check(hi == keep_hi && lo == keep_lo, "R8", "idle hold", hi, keep_hi);

        run_op(2'b11, 32'd1234, 32'd0, 0, "R9");
        run_op(2'b10, 32'hFFFF_0000, 32'd0, 0, "R9");

        run_op(2'b01, 32'd100000, 32'd3000, 1, "R10");
        check(hi == 32'd0 && lo == 32'd300000000, "R10", "scrambled inputs", lo, 32'd300000000);
        run_op(2'b11, 32'd1000, 32'd7, 2, "R3");
        check(lo == 32'd142 && hi == 32'd6, "R3", "start while busy", lo, 32'd142);

        for (int i = 0; i < 120; i++) begin
            logic [1:0] o;
            logic [W-1:0] x, y;
            o = 2'(i % 4);
            x = $urandom;
            y = (i % 8 == 5) ? W'($urandom % 16) : $urandom;
            if (y == '0) y = 32'd1;
            run_op(o, x, y, i % 3,
                   (o == 2'b00) ? "R5" : (o == 2'b01) ? "R4" : (o == 2'b10) ? "R7" : "R6");
        end

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule